// File: doc/BRIEF.md
# Partition Control Register Access Decoder

This block judges every read or write aimed at the hypervisor's partition-control system register. From the exception level of the access, the EL2-enabled status, the two nested-virtualization controls (NV and NV2), whether EL3 exists, and the EL3 trap-lower control, it picks one of five results. The results are: undefined instruction, trap to EL2, trap to EL3, redirect to a memory slot, or direct register access. The result appears as a one-hot vector. A trap also carries its exception class. A redirect also carries the byte offset of the memory slot.

The decision is combinational, so the result is usable in the same cycle as the access strobe. A registered copy of every output follows one cycle later for consumers that need a clean timing boundary. A read and a write go through the same decision tree. The direction flag only passes through to the outputs.

Top module: `sysreg_trap_decoder`

## Requirements
- R1: With `acc_vld`=1 and `cur_el`=0, the outcome is undefined (`res_now` bit 0), whatever the other controls are.
- R2: With `cur_el`=1, `el2_on`=1, `nv`=1 and `nv2`=1, the outcome is memory redirect (bit 3), and `off_now` is 0x930.
- R3: With `cur_el`=1, `el2_on`=1, `nv`=1 and `nv2`=0, the outcome is trap to EL3 (bit 2) when `has_el3` and `el3_trap_low` are both 1. Otherwise the outcome is trap to EL2 (bit 1).
- R4: With `cur_el`=1 and either `el2_on`=0 or `nv`=0, the outcome is undefined (bit 0). This holds even when `nv2`=1.
- R5: With `cur_el`=2, the outcome is trap to EL3 (bit 2) when `has_el3` and `el3_trap_low` are both 1. Otherwise it is direct access (bit 4).
- R6: With `cur_el`=3, the outcome is always direct access (bit 4).
- R7: `ec_now` is 0x18 on either trap outcome and 0 otherwise. `off_now` is 0 for every outcome except redirect.
- R8: `acc_wr` has no effect on the outcome, the class or the offset. It is copied to `wr_q`.
- R9: While `acc_vld`=1, `res_now` has exactly one bit set. While `acc_vld`=0, `res_now`, `ec_now` and `off_now` are all zero.
- R10: `vld_q`, `wr_q`, `res_q`, `ec_q` and `off_q` equal the previous cycle's `acc_vld`, `acc_wr`, `res_now`, `ec_now` and `off_now`. All five are zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the registered copy |
| acc_vld | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| cur_el | input | 2 | Exception level of the access (0..3) |
| el2_on | input | 1 | EL2 enabled in the current security state |
| nv | input | 1 | Nested virtualization control |
| nv2 | input | 1 | Nested virtualization memory-redirect control |
| has_el3 | input | 1 | EL3 implemented |
| el3_trap_low | input | 1 | EL3 trap-lower control |
| res_now | output | 5 | One-hot outcome: 0 undef, 1 trap EL2, 2 trap EL3, 3 redirect, 4 direct |
| ec_now | output | 6 | Exception class for trap outcomes |
| off_now | output | 12 | Memory offset for the redirect outcome |
| vld_q | output | 1 | Registered strobe |
| wr_q | output | 1 | Registered direction |
| res_q | output | 5 | Registered outcome |
| ec_q | output | 6 | Registered class |
| off_q | output | 12 | Registered offset |

## Verification
The bench applies all 512 combinations of level, the five controls, direction and strobe, so every branch of the priority chain is exercised. Pairs that differ only in `nv2` separate a redirect from a trap at EL1, and a case with `nv2`=1 and `nv`=0 catches a decoder that tests NV2 alone. Pairs that differ only in `has_el3` or `el3_trap_low` separate the EL3 pre-emption from EL2 handling and from direct access. Changing only the direction shows that reads and writes get the same result. Strobe-low cycles show that the outputs are forced to zero.

// File: rtl/acc_trap_pkg.sv
package acc_trap_pkg;
  localparam int RES_W    = 5;
  localparam int B_UNDEF  = 0;
  localparam int B_TRAP2  = 1;
  localparam int B_TRAP3  = 2;
  localparam int B_MEM    = 3;
  localparam int B_DIRECT = 4;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_0 = 2'd0;
  localparam lvl_t LVL_1 = 2'd1;
  localparam lvl_t LVL_2 = 2'd2;
  localparam lvl_t LVL_3 = 2'd3;

  typedef struct packed {
    lvl_t lvl;
    logic el2_on;
    logic nv;
    logic nv2;
    logic has_el3;
    logic trap_low;
  } ctl_t;
endpackage

// File: rtl/acc_trap_decode.sv
module acc_trap_decode
  import acc_trap_pkg::*;
#(
  parameter int          EC_W    = 6,
  parameter logic [EC_W-1:0]  EC_VAL  = 6'h18,
  parameter int          OFF_W   = 12,
  parameter logic [OFF_W-1:0] OFF_VAL = 12'h930
) (
  input  logic             vld,
  input  ctl_t             ctl,
  output logic [RES_W-1:0] res,
  output logic [EC_W-1:0]  ec,
  output logic [OFF_W-1:0] off
);
  // EL3 pre-empts lower handling whenever it exists and asks for traps
  function automatic logic el3_claims(input ctl_t c);
    return c.has_el3 & c.trap_low;
  endfunction

  function automatic logic [RES_W-1:0] pick(input ctl_t c);
    logic [RES_W-1:0] r;
    r = '0;
    unique case (c.lvl)
      LVL_0: r[B_UNDEF] = 1'b1;
      LVL_1: begin
        if (c.el2_on && c.nv && c.nv2)  r[B_MEM]   = 1'b1;
        else if (c.el2_on && c.nv)      r[el3_claims(c) ? B_TRAP3 : B_TRAP2] = 1'b1;
        else                            r[B_UNDEF] = 1'b1;
      end
      LVL_2: r[el3_claims(c) ? B_TRAP3 : B_DIRECT] = 1'b1;
      default: r[B_DIRECT] = 1'b1;
    endcase
    return r;
  endfunction

  logic [RES_W-1:0] raw;
  logic             is_trap;
  logic             is_redirect;

  assign raw         = vld ? pick(ctl) : '0;
  assign is_trap     = raw[B_TRAP2] | raw[B_TRAP3];
  assign is_redirect = raw[B_MEM];
  assign res         = raw;
  assign ec          = is_trap ? EC_VAL : '0;
  assign off         = is_redirect ? OFF_VAL : '0;

  always_comb begin
    if (vld) p_onehot_r9: assert ($onehot(res));
    else     p_idle_zero_r9: assert (res == '0 && ec == '0 && off == '0);
  end
endmodule

// File: rtl/acc_trap_stage.sv
module acc_trap_stage
  import acc_trap_pkg::*;
#(
  parameter int EC_W  = 6,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             wr_i,
  input  logic [RES_W-1:0] res_i,
  input  logic [EC_W-1:0]  ec_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             vld_o,
  output logic             wr_o,
  output logic [RES_W-1:0] res_o,
  output logic [EC_W-1:0]  ec_o,
  output logic [OFF_W-1:0] off_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      wr_o  <= 1'b0;
      res_o <= '0;
      ec_o  <= '0;
      off_o <= '0;
    end else begin
      vld_o <= vld_i;
      wr_o  <= wr_i;
      res_o <= res_i;
      ec_o  <= ec_i;
      off_o <= off_i;
    end
  end

  p_pipe_res_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (vld_o && res_o == $past(res_i) && ec_o == $past(ec_i)));
  p_pipe_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> (wr_o == $past(wr_i)));
endmodule

// File: rtl/sysreg_trap_decoder.sv
module sysreg_trap_decoder
  import acc_trap_pkg::*;
#(
  parameter int               EC_W    = 6,
  parameter logic [EC_W-1:0]  EC_VAL  = 6'h18,
  parameter int               OFF_W   = 12,
  parameter logic [OFF_W-1:0] OFF_VAL = 12'h930
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_vld,
  input  logic             acc_wr,
  input  logic [1:0]       cur_el,
  input  logic             el2_on,
  input  logic             nv,
  input  logic             nv2,
  input  logic             has_el3,
  input  logic             el3_trap_low,
  output logic [4:0]       res_now,
  output logic [EC_W-1:0]  ec_now,
  output logic [OFF_W-1:0] off_now,
  output logic             vld_q,
  output logic             wr_q,
  output logic [4:0]       res_q,
  output logic [EC_W-1:0]  ec_q,
  output logic [OFF_W-1:0] off_q
);
  ctl_t ctl;
  assign ctl = '{lvl: cur_el, el2_on: el2_on, nv: nv, nv2: nv2,
                 has_el3: has_el3, trap_low: el3_trap_low};

  acc_trap_decode #(.EC_W(EC_W), .EC_VAL(EC_VAL), .OFF_W(OFF_W), .OFF_VAL(OFF_VAL)) u_dec (
    .vld(acc_vld), .ctl(ctl), .res(res_now), .ec(ec_now), .off(off_now)
  );

  acc_trap_stage #(.EC_W(EC_W), .OFF_W(OFF_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .vld_i(acc_vld), .wr_i(acc_wr), .res_i(res_now), .ec_i(ec_now), .off_i(off_now),
    .vld_o(vld_q), .wr_o(wr_q), .res_o(res_q), .ec_o(ec_q), .off_o(off_q)
  );

  p_el0_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_el == LVL_0) |-> res_now[B_UNDEF]);
  p_redirect_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_now[B_MEM] |-> (off_now == OFF_VAL && cur_el == LVL_1 && nv2));
  p_el3_direct_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && cur_el == LVL_3) |-> res_now[B_DIRECT]);
  p_trap_ec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_now[B_TRAP2] || res_now[B_TRAP3]) |-> (ec_now == EC_VAL && off_now == '0));
  p_trap3_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_now[B_TRAP3] |-> (has_el3 && el3_trap_low));
endmodule

// File: tb/sysreg_trap_decoder_tb.sv
module sysreg_trap_decoder_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_vld = 1'b0, acc_wr = 1'b0, el2_on = 1'b0, nv = 1'b0, nv2 = 1'b0;
  logic has_el3 = 1'b0, el3_trap_low = 1'b0;
  logic [1:0] cur_el = 2'd0;
  logic [4:0] res_now, res_q;
  logic [5:0] ec_now, ec_q;
  logic [11:0] off_now, off_q;
  logic vld_q, wr_q;

  int n_run = 0, n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sysreg_trap_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_wr(acc_wr), .cur_el(cur_el),
    .el2_on(el2_on), .nv(nv), .nv2(nv2), .has_el3(has_el3), .el3_trap_low(el3_trap_low),
    .res_now(res_now), .ec_now(ec_now), .off_now(off_now),
    .vld_q(vld_q), .wr_q(wr_q), .res_q(res_q), .ec_q(ec_q), .off_q(off_q)
  );

  // reference: outcome index, -1 for none
  function automatic int ref_idx(int el, bit e2, bit v, bit v2, bit h3, bit tl, bit valid);
    bit up3 = h3 && tl;
    if (!valid) return -1;
    if (el == 0) return 0;
    if (el == 3) return 4;
    if (el == 2) return up3 ? 2 : 4;
    if (!(e2 && v)) return 0;
    if (v2) return 3;
    return up3 ? 2 : 1;
  endfunction

  function automatic string req_of(int el, bit e2, bit v, bit valid);
    if (!valid) return "R9";
    case (el)
      0: return "R1";
      2: return "R5";
      3: return "R6";
      default: return (e2 && v) ? "R2/R3" : "R4";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  int e_idx = -1;
  bit e_vld = 0, e_wr = 0;

  task automatic check_q(string req);
    int er = (e_idx < 0) ? 0 : (1 << e_idx);
    chk("R10", {req, " res_q"}, int'(res_q), er);
    chk("R10", "vld_q", int'(vld_q), int'(e_vld));
    chk("R8", "wr_q", int'(wr_q), int'(e_wr));
    chk("R10", "ec_q", int'(ec_q), (e_idx == 1 || e_idx == 2) ? 'h18 : 0);
    chk("R10", "off_q", int'(off_q), (e_idx == 3) ? 'h930 : 0);
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (2) @(negedge clk);
    acc_vld = 1'b1; cur_el = 2'd3;
    @(negedge clk);
    chk("R10", "reset res_q", int'(res_q), 0);
    chk("R10", "reset vld_q", int'(vld_q), 0);
    chk("R10", "reset off_q", int'(off_q), 0);
    acc_vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    e_idx = -1; e_vld = 0; e_wr = 0;
    for (int k = 0; k < 512; k++) begin
      int el = k & 3;
      bit e2 = k[2], v = k[3], v2 = k[4], h3 = k[5], tl = k[6], w = k[7], va = k[8];
      int idx;
      string rq;
      @(negedge clk);
      check_q(rq);
      cur_el = el[1:0]; el2_on = e2; nv = v; nv2 = v2;
      has_el3 = h3; el3_trap_low = tl; acc_wr = w; acc_vld = va;
      #1;
      idx = ref_idx(el, e2, v, v2, h3, tl, va);
      rq = req_of(el, e2, v, va);
      chk(rq, "res_now", int'(res_now), (idx < 0) ? 0 : (1 << idx));
      chk("R7", "ec_now", int'(ec_now), (idx == 1 || idx == 2) ? 'h18 : 0);
      chk("R7", "off_now", int'(off_now), (idx == 3) ? 'h930 : 0);
      e_idx = idx; e_vld = va; e_wr = w;
    end
    @(negedge clk);
    check_q("final");
    // direct corner: NV2 alone at EL1 stays undefined (R4); direction irrelevant (R8)
    cur_el = 2'd1; el2_on = 1'b1; nv = 1'b0; nv2 = 1'b1; acc_vld = 1'b1; acc_wr = 1'b1;
    #1;
    chk("R4", "nv2-only res_now", int'(res_now), 1);
    acc_wr = 1'b0;
    #1;
    chk("R8", "read same res_now", int'(res_now), 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule